// File: doc/BRIEF.md
# Cache Maintenance Command Engine

This block sits beside a two-level cache and turns register writes into a stream of per-line maintenance requests. Software picks a ranged operation by writing its start-address register and then its word-count register. The start address is rounded down to a 128-byte line. The count register then acts as a live progress and busy indicator and counts down to zero as the lines are issued. A whole-cache operation starts from a one-bit trigger register and walks every line index of the cache.

One sequencer serves all fourteen operation kinds, so only one operation runs at a time. The same register space holds the second-level cache size mode and one cacheable flag per 16 MB address region. Every request on the output stream carries a 4-bit operation code and a line-aligned byte address. The cache arrays, tag lookup and backing memory are not part of this block.

Top module: `cmce_top`

## Requirements
- R1: After reset, every register reads zero and `req_valid` is low.
- R2: Ranged operations use these start-address/word-count register pairs: 0x4000/0x4004 (second-level writeback, code 1), 0x4010/0x4014 (second-level writeback+invalidate, code 2), 0x4018/0x401C (second-level invalidate, code 3), 0x4020/0x4024 (program first-level invalidate, code 4), 0x4030/0x4034 (data first-level writeback+invalidate, code 5), 0x4040/0x4044 (data first-level writeback, code 6), 0x4048/0x404C (data first-level invalidate, code 7). Writing a nonzero count from bits [15:0] starts that operation. Its first request carries that code and the stored start address with bits [6:0] cleared.
- R3: A ranged operation issues ceil(count/32) requests, one per accepted handshake, at consecutive addresses 128 bytes apart.
- R4: While a ranged operation runs, its count register reads the count minus 32 for each accepted request, floored at zero. It reads zero once the last request is accepted.
- R5: Writing zero to a count register starts nothing.
- R6: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_op` and `req_addr` hold their values.
- R7: Whole-cache triggers sit at 0x5000 (code 9), 0x5004 (code 10), 0x5008 (code 11), 0x5028 (code 12), 0x5044 (code 13), 0x5040 (code 14) and 0x5048 (code 15). Writing with bit 0 set issues GLOBAL_LINES requests at addresses index*128. Bit 0 reads 1 until the last request is accepted. A write with bit 0 clear does nothing.
- R8: While busy, writes to any count or trigger register are ignored, and the running operation's code and sequence are unchanged. Count and trigger registers of idle operations read zero.
- R9: The register at 0x0000 keeps the cache size mode in bits [2:0] (0 none, 1 32K, 2 64K, 3 128K, 7 256K). A write stores only those bits, and bits [31:3] read zero.
- R10: The word at 0x8000 + 4*region (region = address bits [31:24]) holds that region's cacheable flag in bit 0. The other bits read zero, and each region is independent.
- R11: A start-address register reads back all 32 written bits. Rewriting it during a run does not move the running operation's addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Write when high with reg_en |
| reg_addr | input | 16 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| req_valid | output | 1 | Line request present |
| req_ready | input | 1 | Consumer accepts the request |
| req_op | output | 4 | Operation code (1..7 ranged, 9..15 whole cache) |
| req_addr | output | 32 | Line-aligned byte address |

## Verification
The bench targets a count that is not a multiple of 32 and a misaligned start address. An engine that rounded the count the wrong way would drop or add the last line, and one that ignored alignment would emit an unaligned first address. It starts a second operation while one is running and rewrites a start address mid-run. A design that let either through would change the operation code or jump addresses in the middle of a sequence. It also stalls `req_ready` to catch fields that drift, and checks that a zero count or a cleared trigger bit produces no request.

// File: rtl/cmce_pkg.sv
package cmce_pkg;
  localparam int NUM_OPS = 7;
  localparam int OFF_W   = 16;

  typedef logic [2:0] op_idx_t;

  typedef struct packed {
    logic    glob;
    op_idx_t idx;
  } cur_op_t;

  // start-address registers; the count register sits one word above each
  localparam logic [OFF_W-1:0] BAR_OFF [NUM_OPS] = '{
    16'h4000, 16'h4010, 16'h4018, 16'h4020, 16'h4030, 16'h4040, 16'h4048};
  // whole-cache trigger registers, same operation order as above
  localparam logic [OFF_W-1:0] TRIG_OFF [NUM_OPS] = '{
    16'h5000, 16'h5004, 16'h5008, 16'h5028, 16'h5044, 16'h5040, 16'h5048};
  localparam logic [OFF_W-1:0] CFG_OFF = 16'h0000;
  localparam logic [OFF_W:0]   MAR_LO  = 17'h08000;

  function automatic logic [3:0] op_code(cur_op_t c);
    return {c.glob, c.idx + 3'd1};
  endfunction
endpackage

// File: rtl/cmce_rst_sync.sv
module cmce_rst_sync (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) sync_q <= 2'b00;
    else              sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cmce_seq.sv
module cmce_seq
  import cmce_pkg::*;
#(
  parameter int LINE_BYTES   = 128,
  parameter int GLOBAL_LINES = 256,
  parameter int CNT_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_glob,
  input  op_idx_t          start_idx,
  input  logic [31:0]      start_addr,
  input  logic [15:0]      start_cnt,
  input  logic             req_ready,
  output logic             req_valid,
  output logic [3:0]       req_op,
  output logic [31:0]      req_addr,
  output logic             busy,
  output cur_op_t          cur,
  output logic [CNT_W-1:0] rem
);
  localparam int WPL        = LINE_BYTES / 4;
  localparam int GLOB_WORDS = GLOBAL_LINES * WPL;
  localparam logic [31:0] LINE_MASK = 32'(LINE_BYTES - 1);

  logic [CNT_W-1:0] rem_q, rem_d;
  logic [31:0]      addr_q, addr_d;
  cur_op_t          cur_q, cur_d;
  logic             load, accept, upd_en;

  assign busy   = (rem_q != '0);
  assign load   = start & ~busy;
  assign accept = busy & req_ready;
  assign upd_en = load | accept;

  always_comb begin
    rem_d  = rem_q;
    addr_d = addr_q;
    cur_d  = cur_q;
    if (load) begin
      cur_d.glob = start_glob;
      cur_d.idx  = start_idx;
      if (start_glob) begin
        rem_d  = CNT_W'(GLOB_WORDS);
        addr_d = '0;
      end else begin
        rem_d  = CNT_W'(start_cnt);
        addr_d = start_addr & ~LINE_MASK;
      end
    end else if (accept) begin
      rem_d  = (rem_q > CNT_W'(WPL)) ? rem_q - CNT_W'(WPL) : '0;
      addr_d = addr_q + 32'(LINE_BYTES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      addr_q <= '0;
      cur_q  <= '0;
    end else if (upd_en) begin
      rem_q  <= rem_d;
      addr_q <= addr_d;
      cur_q  <= cur_d;
    end
  end

  assign req_valid = busy;
  assign req_op    = op_code(cur_q);
  assign req_addr  = addr_q;
  assign cur       = cur_q;
  assign rem       = rem_q;

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_op) && $stable(req_addr));
  assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr & LINE_MASK) == 32'd0);
  assert_line_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && rem_q > CNT_W'(WPL)
      |=> req_valid && req_addr == $past(req_addr) + 32'(LINE_BYTES));
  assert_last_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && rem_q <= CNT_W'(WPL) |=> !req_valid);
  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rem_q < $past(rem_q));
  assert_owner_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(req_ready && rem_q <= CNT_W'(WPL)) |=> $stable(cur_q) && busy);
endmodule

// File: rtl/cmce_regs.sv
module cmce_regs
  import cmce_pkg::*;
#(
  parameter int MAR_REGIONS = 256,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_en,
  input  logic             reg_we,
  input  logic [15:0]      reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             busy,
  input  cur_op_t          cur,
  input  logic [CNT_W-1:0] rem,
  output logic             start,
  output logic             start_glob,
  output op_idx_t          start_idx,
  output logic [31:0]      start_addr,
  output logic [15:0]      start_cnt
);
  localparam int MAR_IDX_W = (MAR_REGIONS > 1) ? $clog2(MAR_REGIONS) : 1;
  localparam logic [OFF_W:0] MAR_HI = MAR_LO + 17'(4 * MAR_REGIONS);

  logic                   wr;
  logic [31:0]            bar_q [NUM_OPS];
  logic [2:0]             mode_q;
  logic [MAR_REGIONS-1:0] mar_q;
  logic                   mode_en, mar_hit, mar_en;
  logic [MAR_IDX_W-1:0]   mar_sel;

  assign wr      = reg_en & reg_we;
  assign mode_en = wr && (reg_addr == CFG_OFF);
  assign mar_hit = ({1'b0, reg_addr} >= MAR_LO) && ({1'b0, reg_addr} < MAR_HI)
                   && (reg_addr[1:0] == 2'b00);
  assign mar_en  = wr && mar_hit;
  assign mar_sel = reg_addr[2 +: MAR_IDX_W];

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_bar
    logic bar_en;
    assign bar_en = wr && (reg_addr == BAR_OFF[k]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bar_q[k] <= '0;
      else if (bar_en) bar_q[k] <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_en) mode_q <= reg_wdata[2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mar_q <= '0;
    else if (mar_en) mar_q[mar_sel] <= reg_wdata[0];
  end

  // command decode: only one register matches any offset
  always_comb begin
    start      = 1'b0;
    start_glob = 1'b0;
    start_idx  = '0;
    start_addr = '0;
    start_cnt  = '0;
    for (int k = 0; k < NUM_OPS; k++) begin
      if (wr && !busy && reg_addr == BAR_OFF[k] + 16'd4 && reg_wdata[15:0] != 16'd0) begin
        start      = 1'b1;
        start_idx  = 3'(k);
        start_addr = bar_q[k];
        start_cnt  = reg_wdata[15:0];
      end
      if (wr && !busy && reg_addr == TRIG_OFF[k] && reg_wdata[0]) begin
        start      = 1'b1;
        start_glob = 1'b1;
        start_idx  = 3'(k);
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CFG_OFF) reg_rdata[2:0] = mode_q;
    if (mar_hit)             reg_rdata[0]   = mar_q[mar_sel];
    for (int k = 0; k < NUM_OPS; k++) begin
      if (reg_addr == BAR_OFF[k]) reg_rdata = bar_q[k];
      if (reg_addr == BAR_OFF[k] + 16'd4 && busy && !cur.glob && cur.idx == 3'(k))
        reg_rdata[15:0] = rem[15:0];
      if (reg_addr == TRIG_OFF[k] && busy && cur.glob && cur.idx == 3'(k))
        reg_rdata[0] = 1'b1;
    end
  end

  assert_mode_only_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> $stable(mode_q));
  assert_mar_only_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mar_en |=> $stable(mar_q));
endmodule

// File: rtl/cmce_top.sv
module cmce_top
  import cmce_pkg::*;
#(
  parameter int LINE_BYTES   = 128,
  parameter int GLOBAL_LINES = 256,
  parameter int MAR_REGIONS  = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_en,
  input  logic        reg_we,
  input  logic [15:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [3:0]  req_op,
  output logic [31:0] req_addr
);
  localparam int WPL        = LINE_BYTES / 4;
  localparam int GLOB_CW    = $clog2(GLOBAL_LINES * WPL + 1);
  localparam int CNT_W      = (GLOB_CW > 16) ? GLOB_CW : 16;

  logic             rst_sync_n;
  logic             busy, start, start_glob;
  op_idx_t          start_idx;
  logic [31:0]      start_addr;
  logic [15:0]      start_cnt;
  cur_op_t          cur;
  logic [CNT_W-1:0] rem;

  cmce_rst_sync u_rst (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_sync_n)
  );

  cmce_regs #(.MAR_REGIONS(MAR_REGIONS), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .reg_en     (reg_en),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .busy       (busy),
    .cur        (cur),
    .rem        (rem),
    .start      (start),
    .start_glob (start_glob),
    .start_idx  (start_idx),
    .start_addr (start_addr),
    .start_cnt  (start_cnt)
  );

  cmce_seq #(.LINE_BYTES(LINE_BYTES), .GLOBAL_LINES(GLOBAL_LINES), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .start_glob (start_glob),
    .start_idx  (start_idx),
    .start_addr (start_addr),
    .start_cnt  (start_cnt),
    .req_ready  (req_ready),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .busy       (busy),
    .cur        (cur),
    .rem        (rem)
  );
endmodule

// File: tb/cmce_top_tb.sv
module cmce_top_tb;
  localparam int LINE = 128;
  localparam int GLINES = 256;

  localparam logic [15:0] T_BAR  [7] = '{16'h4000, 16'h4010, 16'h4018, 16'h4020,
                                         16'h4030, 16'h4040, 16'h4048};
  localparam logic [15:0] T_TRIG [7] = '{16'h5000, 16'h5004, 16'h5008, 16'h5028,
                                         16'h5044, 16'h5040, 16'h5048};
  // {op index, start address, word count}
  localparam logic [51:0] VEC [8] = '{
    {4'd0, 32'h0000_1000, 16'd64},
    {4'd1, 32'h1234_5678, 16'd1},
    {4'd2, 32'h8000_0040, 16'd33},
    {4'd3, 32'h0000_0F80, 16'd32},
    {4'd4, 32'h00AB_CDEF, 16'd100},
    {4'd5, 32'h7FFF_FF00, 16'd64},
    {4'd6, 32'h0FFF_FF80, 16'd96},
    {4'd0, 32'h0000_0000, 16'd31}};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_en, reg_we, req_ready;
  logic [15:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata, req_addr;
  logic        req_valid;
  logic [3:0]  req_op;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  cmce_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // called at a negedge with req_ready high; reg_addr selects the count register
  task automatic collect(input logic [3:0] eop, input logic [31:0] first, input int wc,
                         input bit glob, output int n, output int bad);
    n = 0; bad = 0;
    for (int g = 0; g < 5000 && req_valid; g++) begin
      int left;
      left = wc - 32 * n;
      if (left < 0) left = 0;
      if (req_op !== eop || req_addr !== first + 32'(n * LINE)) bad++;
      if (!glob && reg_rdata !== 32'(left)) bad++;
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n, bad;
    rst_n = 1'b0; reg_en = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; req_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(16'h4004, v); chk(v == 0, "R1 count reg", v, 0);
    rd(16'h4000, v); chk(v == 0, "R1 start addr reg", v, 0);
    rd(16'h0000, v); chk(v == 0, "R1 mode reg", v, 0);
    rd(16'h5000, v); chk(v == 0, "R1 trigger reg", v, 0);
    rd(16'h8000, v); chk(v == 0, "R1 region reg", v, 0);
    chk(req_valid == 0, "R1 req_valid", 32'(req_valid), 0);

    // table-driven ranged operations: R2 R3 R4 R6
    foreach (VEC[i]) begin
      int op, wc, lines;
      logic [31:0] base, first;
      op = int'(VEC[i][51:48]); base = VEC[i][47:32]; wc = int'(VEC[i][15:0]);
      base = VEC[i][47:16];
      lines = (wc + 31) / 32;
      first = base & 32'hFFFF_FF80;
      req_ready = 1'b0;
      wr(T_BAR[op], base);
      wr(T_BAR[op] + 16'd4, 32'(wc));
      #1;
      chk(reg_rdata == 32'(wc), "R4 count readback at start", reg_rdata, 32'(wc));
      chk(req_valid && req_op == 4'(op + 1) && req_addr == first, "R2 first request",
          {req_op, req_addr[27:0]}, {4'(op + 1), first[27:0]});
      @(negedge clk);
      chk(req_valid && req_op == 4'(op + 1) && req_addr == first, "R6 held under stall",
          req_addr, first);
      req_ready = 1'b1;
      collect(4'(op + 1), first, wc, 1'b0, n, bad);
      chk(n == lines && bad == 0, "R3 R4 line sequence", 32'(n), 32'(lines));
      #1 chk(reg_rdata == 0, "R4 count reads zero when done", reg_rdata, 0);
    end

    // R3 largest command
    req_ready = 1'b1;
    wr(16'h4018, 32'h2000_0000);
    wr(16'h401C, 32'h0000_FFFF);
    collect(4'd3, 32'h2000_0000, 65535, 1'b0, n, bad);
    chk(n == 2048 && bad == 0, "R3 max count lines", 32'(n), 32'd2048);

    // R5 zero count starts nothing
    wr(16'h4044, 32'h0);
    @(negedge clk);
    chk(req_valid == 0, "R5 zero count no request", 32'(req_valid), 0);
    rd(16'h4044, v); chk(v == 0, "R5 count stays zero", v, 0);

    // R8 commands while busy are ignored
    req_ready = 1'b0;
    wr(16'h4000, 32'h0000_2000);
    wr(16'h4004, 32'd64);
    wr(16'h4014, 32'd32);
    wr(16'h5008, 32'd1);
    rd(16'h4014, v); chk(v == 0, "R8 idle count reg reads zero", v, 0);
    rd(16'h5008, v); chk(v == 0, "R8 idle trigger reads zero", v, 0);
    chk(req_op == 4'd1, "R8 running op kept", 32'(req_op), 1);
    rd(16'h4004, v);
    req_ready = 1'b1;
    collect(4'd1, 32'h0000_2000, 64, 1'b0, n, bad);
    chk(n == 2 && bad == 0, "R8 only original lines", 32'(n), 2);
    @(negedge clk);
    chk(req_valid == 0, "R8 nothing queued after", 32'(req_valid), 0);

    // R11 start address readback and mid-run rewrite
    req_ready = 1'b0;
    wr(16'h4020, 32'h4000_0000);
    wr(16'h4024, 32'd64);
    wr(16'h4020, 32'h5000_0044);
    rd(16'h4020, v); chk(v == 32'h5000_0044, "R11 full readback", v, 32'h5000_0044);
    rd(16'h4024, v);
    req_ready = 1'b1;
    collect(4'd4, 32'h4000_0000, 64, 1'b0, n, bad);
    chk(n == 2 && bad == 0, "R11 running addresses unchanged", 32'(n), 2);

    // R7 whole-cache operation
    wr(16'h5044, 32'd1);
    #1 chk(reg_rdata[0] == 1'b1, "R7 trigger reads busy", reg_rdata, 1);
    collect(4'd13, 32'h0, 0, 1'b1, n, bad);
    chk(n == GLINES && bad == 0, "R7 whole-cache lines", 32'(n), 32'(GLINES));
    #1 chk(reg_rdata == 0, "R7 trigger clears", reg_rdata, 0);
    wr(16'h5000, 32'd2);
    @(negedge clk);
    chk(req_valid == 0, "R7 bit0 clear no start", 32'(req_valid), 0);

    // R9 mode field
    wr(16'h0000, 32'hFFFF_FFFF);
    rd(16'h0000, v); chk(v == 32'd7, "R9 only mode bits kept", v, 7);
    wr(16'h0000, 32'hFFFF_FFF2);
    rd(16'h0000, v); chk(v == 32'd2, "R9 mode rewrite", v, 2);

    // R10 region flags
    wr(16'h8048, 32'hFFFF_FFFF);
    rd(16'h8048, v); chk(v == 32'd1, "R10 region set", v, 1);
    rd(16'h804C, v); chk(v == 32'd0, "R10 neighbour untouched", v, 0);
    rd(16'h83FC, v); chk(v == 32'd0, "R10 last region clear", v, 0);
    wr(16'h8048, 32'hFFFF_FFFE);
    rd(16'h8048, v); chk(v == 32'd0, "R10 region cleared", v, 0);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule